// File: doc/BRIEF.md
# Prescaled PWM Time-Base Counter

This block is the timing core of a PWM generator. It keeps a 16-bit counter that moves one step per prescaler tick and follows one of four count modes: counting up with wrap, counting down with reload, counting up and down between zero and the period, or frozen. The prescaler divides the system clock by the product of a power-of-two factor and an even factor. The period register is either double-buffered through a shadow copy or written straight into the active copy.

Software programs four registers through a simple write port: control, period, compare A and compare B. Downstream logic, such as waveform shaping and interrupt sources, uses the counter value, the prescaled tick, and one-cycle strobes for four events. These events are counter at zero, counter at period, counter equal to compare A while rising, and counter equal to compare B while rising.

Top module: `pwm_timebase`

## Requirements
- R1: Writes with `wrEn` high go to control (address 0), period (1), compare A (2) or compare B (3). Reset clears all four registers and the counter, so the block starts in up-count, shadowed period, divide-by-1, with all event strobes low.
- R2: Control bits 12:10 hold a code n and bits 9:7 hold a code m. `tick` is high for one cycle in every F system cycles, where F = 2^n * (m == 0 ? 1 : 2*m), up to 1792.
- R3: The counter changes only in the cycle after a cycle in which `tick` was high.
- R4: With mode bits 1:0 = 00, the counter steps 0, 1, ..., P and then back to 0, where P is the active period. `evtZero` is high during the first cycle the counter shows 0, and `evtPeriod` is high during the first cycle it shows P.
- R5: With mode bits = 01, the counter steps down by one and reloads P after showing 0.
- R6: With mode bits = 10, the counter rises to P, then falls to 0, then rises again, showing each end value only once per turn.
- R7: With mode bits = 11, the counter holds its value and no event strobe fires.
- R8: With control bit 3 = 0, a period write goes to a shadow copy. The shadow copy becomes active on the step that brings the counter to 0.
- R9: With control bit 3 = 1, a period write takes effect on the next step. A counter at or above the new period then wraps to 0.
- R10: `evtCmpAUp` (`evtCmpBUp`) is high during the first cycle the counter equals compare A (compare B) after a rising step. Up-count mode counts every step as rising. Down-count mode counts no step as rising.
- R11: A control write that changes bits 12:7 restarts the prescaler, so the next tick comes F cycles later. A control write that leaves bits 12:7 unchanged does not disturb the prescaler phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register select: 0 control, 1 period, 2 compare A, 3 compare B |
| wrData | input | 16 | Write data |
| count | output | 16 | Current counter value |
| tick | output | 1 | Prescaled tick, one system cycle wide |
| evtZero | output | 1 | Counter reached zero |
| evtPeriod | output | 1 | Counter reached the active period |
| evtCmpAUp | output | 1 | Counter reached compare A on a rising step |
| evtCmpBUp | output | 1 | Counter reached compare B on a rising step |

## Verification
The bench builds the block with its default parameters: a 16-bit counter and 3-bit codes for both dividers. The largest prescale, 1792 cycles, can therefore be measured directly alongside small ones such as 1, 2, 8 and 24. Periods of 2 to 4 keep each count sequence short, so every mode, the shadow-versus-immediate period swap, and the up-only compare events can be stepped cycle by cycle. The prescaler restart is told apart from a plain phase continuation by the cycles between a control write and the next tick.

// File: rtl/pwm_tb_pkg.sv
package pwm_tb_pkg;

  typedef enum logic [1:0] {
    MODE_UP     = 2'b00,
    MODE_DOWN   = 2'b01,
    MODE_UPDOWN = 2'b10,
    MODE_FREEZE = 2'b11
  } cntMode_e;

  // bit positions inside the control word
  localparam int MODE_LSB  = 0;
  localparam int PRDLD_BIT = 3;
  localparam int HSDIV_LSB = 7;
  localparam int CKDIV_LSB = 10;

  // register select codes
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_PRD  = 2'd1;
  localparam logic [1:0] ADDR_CMPA = 2'd2;
  localparam logic [1:0] ADDR_CMPB = 2'd3;

  // strobes from the control side to the counter datapath
  typedef struct packed {
    logic     tick;
    cntMode_e mode;
  } tbCtl_t;

endpackage

// File: rtl/pwm_tb_ctrl.sv
module pwm_tb_ctrl
  import pwm_tb_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int CKDIV_W = 3,
  parameter int HSDIV_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              zeroReach,
  output tbCtl_t            ctl,
  output logic [DATA_W-1:0] activePrd,
  output logic [DATA_W-1:0] cmpA,
  output logic [DATA_W-1:0] cmpB
);

  // widest prescale is 2^(2^CKDIV_W-1) * 2*(2^HSDIV_W-1)
  localparam int PS_W = (1 << CKDIV_W) - 1 + HSDIV_W + 1;

  cntMode_e           modeReg;
  logic               prdImm;
  logic [HSDIV_W-1:0] hsCode;
  logic [CKDIV_W-1:0] ckCode;
  logic [DATA_W-1:0]  shadowPrd;
  logic [PS_W-1:0]    prescCnt;
  logic [PS_W-1:0]    hsFactor;
  logic [PS_W-1:0]    psFactor;
  logic [PS_W-1:0]    psLast;
  logic               wrCtrl, wrPrd, wrCmpA, wrCmpB;
  logic               divChange;
  logic               tickNow;

  assign wrCtrl = wrEn && (wrAddr == ADDR_CTRL);
  assign wrPrd  = wrEn && (wrAddr == ADDR_PRD);
  assign wrCmpA = wrEn && (wrAddr == ADDR_CMPA);
  assign wrCmpB = wrEn && (wrAddr == ADDR_CMPB);

  always_comb begin
    hsFactor = (hsCode == '0) ? PS_W'(1) : PS_W'({hsCode, 1'b0});
    psFactor = hsFactor << ckCode;
    psLast   = psFactor - 1'b1;
  end

  assign tickNow   = (prescCnt == psLast);
  assign divChange = (wrData[HSDIV_LSB +: HSDIV_W] != hsCode) ||
                     (wrData[CKDIV_LSB +: CKDIV_W] != ckCode);

  // prescaler: restarts on a divider change, wraps on its last count
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prescCnt <= '0;
    end else if (wrCtrl && divChange) begin
      prescCnt <= '0;
    end else if (tickNow) begin
      prescCnt <= '0;
    end else begin
      prescCnt <= prescCnt + 1'b1;
    end
  end

  // control fields
  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg <= MODE_UP;
      prdImm  <= 1'b0;
      hsCode  <= '0;
      ckCode  <= '0;
    end else if (wrCtrl) begin
      modeReg <= cntMode_e'(wrData[MODE_LSB +: 2]);
      prdImm  <= wrData[PRDLD_BIT];
      hsCode  <= wrData[HSDIV_LSB +: HSDIV_W];
      ckCode  <= wrData[CKDIV_LSB +: CKDIV_W];
    end
  end

  // period: shadow copy always written, active copy at zero or at once
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowPrd <= '0;
      activePrd <= '0;
    end else begin
      if (wrPrd) begin
        shadowPrd <= wrData;
      end
      if (zeroReach) begin
        activePrd <= shadowPrd;
      end
      if (wrPrd && prdImm) begin
        activePrd <= wrData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpA <= '0;
      cmpB <= '0;
    end else begin
      if (wrCmpA) cmpA <= wrData;
      if (wrCmpB) cmpB <= wrData;
    end
  end

  assign ctl.tick = tickNow;
  assign ctl.mode = modeReg;

endmodule

// File: rtl/pwm_tb_count.sv
module pwm_tb_count
  import pwm_tb_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  tbCtl_t            ctl,
  input  logic [DATA_W-1:0] activePrd,
  input  logic [DATA_W-1:0] cmpA,
  input  logic [DATA_W-1:0] cmpB,
  output logic [DATA_W-1:0] count,
  output logic              zeroReach,
  output logic              evtZero,
  output logic              evtPeriod,
  output logic              evtCmpAUp,
  output logic              evtCmpBUp
);

  logic [DATA_W-1:0] nextCnt;
  logic              dirUp;
  logic              nextDir;
  logic              stepUp;
  logic              advance;

  always_comb begin
    nextCnt = count;
    nextDir = dirUp;
    stepUp  = 1'b0;
    unique case (ctl.mode)
      MODE_UP: begin
        stepUp  = 1'b1;
        nextCnt = (count >= activePrd) ? '0 : count + 1'b1;
      end
      MODE_DOWN: begin
        nextCnt = (count == '0 || count > activePrd) ? activePrd : count - 1'b1;
      end
      MODE_UPDOWN: begin
        if (dirUp) begin
          if (count < activePrd) begin
            nextCnt = count + 1'b1;
            stepUp  = 1'b1;
          end else if (count != '0) begin
            nextCnt = count - 1'b1;
            nextDir = 1'b0;
          end
        end else begin
          if (count != '0) begin
            nextCnt = count - 1'b1;
          end else if (activePrd != '0) begin
            nextCnt = {{(DATA_W-1){1'b0}}, 1'b1};
            nextDir = 1'b1;
            stepUp  = 1'b1;
          end
        end
      end
      default: begin
        nextCnt = count;
      end
    endcase
  end

  assign advance   = ctl.tick && (ctl.mode != MODE_FREEZE);
  assign zeroReach = advance && (nextCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count     <= '0;
      dirUp     <= 1'b1;
      evtZero   <= 1'b0;
      evtPeriod <= 1'b0;
      evtCmpAUp <= 1'b0;
      evtCmpBUp <= 1'b0;
    end else begin
      if (advance) begin
        count <= nextCnt;
        dirUp <= nextDir;
      end
      evtZero   <= zeroReach;
      evtPeriod <= advance && (nextCnt == activePrd);
      evtCmpAUp <= advance && stepUp && (nextCnt == cmpA);
      evtCmpBUp <= advance && stepUp && (nextCnt == cmpB);
    end
  end

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_tb_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int CKDIV_W = 3,
  parameter int HSDIV_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] count,
  output logic              tick,
  output logic              evtZero,
  output logic              evtPeriod,
  output logic              evtCmpAUp,
  output logic              evtCmpBUp
);

  tbCtl_t            ctl;
  logic [DATA_W-1:0] activePrd;
  logic [DATA_W-1:0] cmpAVal;
  logic [DATA_W-1:0] cmpBVal;
  logic              zeroReach;

  pwm_tb_ctrl #(
    .DATA_W (DATA_W),
    .CKDIV_W(CKDIV_W),
    .HSDIV_W(HSDIV_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .zeroReach(zeroReach),
    .ctl      (ctl),
    .activePrd(activePrd),
    .cmpA     (cmpAVal),
    .cmpB     (cmpBVal)
  );

  pwm_tb_count #(
    .DATA_W(DATA_W)
  ) u_count (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .activePrd(activePrd),
    .cmpA     (cmpAVal),
    .cmpB     (cmpBVal),
    .count    (count),
    .zeroReach(zeroReach),
    .evtZero  (evtZero),
    .evtPeriod(evtPeriod),
    .evtCmpAUp(evtCmpAUp),
    .evtCmpBUp(evtCmpBUp)
  );

  assign tick = ctl.tick;

endmodule

// File: rtl/pwm_timebase_chk.sv
module pwm_timebase_chk
  import pwm_tb_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              tick,
  input cntMode_e          mode,
  input logic [DATA_W-1:0] count,
  input logic [DATA_W-1:0] activePrd,
  input logic [DATA_W-1:0] cmpA,
  input logic              evtZero,
  input logic              evtPeriod,
  input logic              evtCmpAUp
);

  // R3
  stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> $stable(count));

  // R4
  zero_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    evtZero |-> (count == '0));

  // R4
  period_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    evtPeriod |-> (count == $past(activePrd)));

  // R4
  up_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tick && mode == MODE_UP && count < activePrd) |=> (count == $past(count) + 1'b1));

  // R5
  down_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tick && mode == MODE_DOWN && count != '0 && count <= activePrd)
      |=> (count == $past(count) - 1'b1));

  // R7
  freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_FREEZE) |=> ($stable(count) && !evtZero && !evtPeriod));

  // R10
  cmpa_chk: assert property (@(posedge clk) disable iff (!rstN)
    evtCmpAUp |-> (count == $past(cmpA)));

endmodule

bind pwm_timebase pwm_timebase_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .tick     (tick),
  .mode     (ctl.mode),
  .count    (count),
  .activePrd(activePrd),
  .cmpA     (cmpAVal),
  .evtZero  (evtZero),
  .evtPeriod(evtPeriod),
  .evtCmpAUp(evtCmpAUp)
);

// File: tb/sim_pwm_timebase.sv
module sim_pwm_timebase;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = 2'd0;
  logic [15:0] wrData = 16'd0;
  logic [15:0] count;
  logic        tick, evtZero, evtPeriod, evtCmpAUp, evtCmpBUp;

  int nTotal = 0;
  int nPass  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  pwm_timebase u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .count(count), .tick(tick), .evtZero(evtZero), .evtPeriod(evtPeriod),
    .evtCmpAUp(evtCmpAUp), .evtCmpBUp(evtCmpBUp)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nTotal++;
    if (ok) nPass++;
    else $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [15:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk);
    #1;
    wrEn = 1'b0;
  endtask

  function automatic logic [15:0] mkCtrl(input logic [1:0] md, input logic imm,
                                         input logic [2:0] hs, input logic [2:0] ck);
    return {3'b000, ck, hs, 3'b000, imm, 1'b0, md};
  endfunction

  task automatic waitZero(input string req);
    int g = 0;
    while (!evtZero && g < 5000) begin
      step(1);
      g++;
    end
    chk(evtZero && count == 0, req, int'(count), 0);
  endtask

  task automatic waitTick(output int g);
    g = 0;
    while (!tick && g < 5000) begin
      step(1);
      g++;
    end
  endtask

  // R1: reset state
  task automatic testReset();
    chk(count == 0, "R1 count in reset", int'(count), 0);
    chk({evtZero, evtPeriod, evtCmpAUp, evtCmpBUp} == 4'b0, "R1 strobes in reset",
        int'({evtZero, evtPeriod, evtCmpAUp, evtCmpBUp}), 0);
    @(posedge clk); #1; rstN = 1'b1;
    chk(count == 0, "R1 count after reset", int'(count), 0);
  endtask

  // R4 / R10: up count with compare A at 3
  task automatic testUp();
    int exp[6] = '{1, 2, 3, 4, 0, 1};
    wrReg(2'd2, 16'd3);
    wrReg(2'd1, 16'd4);
    wrReg(2'd0, mkCtrl(2'b00, 1'b0, 3'd0, 3'd0));
    step(2);
    waitZero("R4 up reaches zero");
    waitZero("R4 up reaches zero again");
    step(1);
    if (count == 0) step(1);
    step(0);
    waitZero("R4 up sync");
    for (int i = 0; i < 6; i++) begin
      step(1);
      chk(count == exp[i], "R4 up count", int'(count), exp[i]);
      chk(evtPeriod == (exp[i] == 4), "R4 up period strobe", int'(evtPeriod), int'(exp[i] == 4));
      chk(evtZero == (exp[i] == 0), "R4 up zero strobe", int'(evtZero), int'(exp[i] == 0));
      chk(evtCmpAUp == (exp[i] == 3), "R10 up compare A", int'(evtCmpAUp), int'(exp[i] == 3));
    end
  endtask

  // R5 / R10: down count, compare never fires
  task automatic testDown();
    int exp[6] = '{4, 3, 2, 1, 0, 4};
    wrReg(2'd0, mkCtrl(2'b01, 1'b0, 3'd0, 3'd0));
    step(2);
    waitZero("R5 down reaches zero");
    for (int i = 0; i < 6; i++) begin
      step(1);
      chk(count == exp[i], "R5 down count", int'(count), exp[i]);
      chk(evtPeriod == (exp[i] == 4), "R5 down period strobe", int'(evtPeriod), int'(exp[i] == 4));
      chk(evtCmpAUp == 1'b0, "R10 down no compare A", int'(evtCmpAUp), 0);
    end
  endtask

  // R6 / R10 / R8: up-down with period 3, compare A 2, compare B 1
  task automatic testUpDown();
    int exp[7]  = '{1, 2, 3, 2, 1, 0, 1};
    int expA[7] = '{0, 1, 0, 0, 0, 0, 0};
    int expB[7] = '{1, 0, 0, 0, 0, 0, 1};
    wrReg(2'd0, mkCtrl(2'b10, 1'b0, 3'd0, 3'd0));
    wrReg(2'd1, 16'd3);
    wrReg(2'd2, 16'd2);
    wrReg(2'd3, 16'd1);
    step(2);
    waitZero("R6 updown reaches zero");
    for (int i = 0; i < 7; i++) begin
      step(1);
      chk(count == exp[i], "R6 updown count", int'(count), exp[i]);
      chk(evtPeriod == (exp[i] == 3), "R6 updown period strobe", int'(evtPeriod), int'(exp[i] == 3));
      chk(evtCmpAUp == expA[i][0], "R10 updown compare A", int'(evtCmpAUp), expA[i]);
      chk(evtCmpBUp == expB[i][0], "R10 updown compare B", int'(evtCmpBUp), expB[i]);
    end
  endtask

  // R7: frozen
  task automatic testFreeze();
    logic [15:0] held;
    wrReg(2'd0, mkCtrl(2'b11, 1'b0, 3'd0, 3'd0));
    step(1);
    held = count;
    for (int i = 0; i < 10; i++) begin
      step(1);
      chk(count == held, "R7 freeze holds", int'(count), int'(held));
      chk(!evtZero && !evtPeriod && !evtCmpAUp, "R7 freeze no strobes",
          int'({evtZero, evtPeriod, evtCmpAUp}), 0);
    end
  endtask

  // R8: shadowed period write waits for zero
  task automatic testShadow();
    int exp[7] = '{2, 3, 4, 0, 1, 2, 0};
    wrReg(2'd0, mkCtrl(2'b00, 1'b0, 3'd0, 3'd0));
    wrReg(2'd1, 16'd4);
    step(2);
    waitZero("R8 sync");
    waitZero("R8 sync again");
    wrReg(2'd1, 16'd2);
    chk(count == 1, "R8 shadow first step", int'(count), 1);
    for (int i = 0; i < 7; i++) begin
      step(1);
      chk(count == exp[i], "R8 shadow count", int'(count), exp[i]);
    end
  endtask

  // R9: immediate period write
  task automatic testImmediate();
    int exp[5] = '{2, 0, 1, 2, 0};
    wrReg(2'd1, 16'd4);
    wrReg(2'd0, mkCtrl(2'b00, 1'b1, 3'd0, 3'd0));
    step(2);
    waitZero("R9 sync");
    waitZero("R9 sync again");
    wrReg(2'd1, 16'd2);
    chk(count == 1, "R9 immediate first step", int'(count), 1);
    for (int i = 0; i < 5; i++) begin
      step(1);
      chk(count == exp[i], "R9 immediate count", int'(count), exp[i]);
    end
  endtask

  // R2: tick spacing for several divider codes
  task automatic testPrescale();
    int hsC[6] = '{0, 2, 3, 7, 0, 1};
    int ckC[6] = '{0, 1, 2, 7, 3, 0};
    int fac[6] = '{1, 8, 24, 1792, 8, 2};
    int g;
    for (int i = 0; i < 6; i++) begin
      wrReg(2'd0, mkCtrl(2'b00, 1'b0, 3'(hsC[i]), 3'(ckC[i])));
      waitTick(g);
      step(1);
      g = 1;
      while (!tick && g < 5000) begin
        step(1);
        g++;
      end
      chk(g == fac[i], "R2 tick spacing", g, fac[i]);
    end
  endtask

  // R3: counter moves once per tick at prescale 24
  task automatic testAdvance();
    int g;
    logic [15:0] c0, c1;
    wrReg(2'd1, 16'd4);
    wrReg(2'd0, mkCtrl(2'b00, 1'b0, 3'd3, 3'd2));
    waitTick(g);
    waitTick(g);
    c0 = count;
    step(1);
    c1 = count;
    chk(c1 == ((c0 + 1) % 5), "R3 step on tick", int'(c1), int'((c0 + 1) % 5));
    for (int i = 0; i < 23; i++) begin
      step(1);
      chk(count == c1, "R3 hold between ticks", int'(count), int'(c1));
    end
  endtask

  // R11: prescaler restart only on divider change
  task automatic testRestart();
    int g;
    wrReg(2'd0, mkCtrl(2'b00, 1'b0, 3'd3, 3'd2));
    waitTick(g);
    waitTick(g);
    step(2);
    wrReg(2'd0, mkCtrl(2'b00, 1'b0, 3'd2, 3'd1));
    waitTick(g);
    chk(g == 7, "R11 restart on divider change", g, 7);
    step(1);
    waitTick(g);
    step(2);
    wrReg(2'd0, mkCtrl(2'b01, 1'b0, 3'd2, 3'd1));
    waitTick(g);
    chk(g == 5, "R11 no restart on mode-only write", g, 5);
  endtask

  initial begin
    step(3);
    testReset();
    testUp();
    testDown();
    testUpDown();
    testFreeze();
    testShadow();
    testImmediate();
    testPrescale();
    testAdvance();
    testRestart();
    finished = 1;
    $display("%0d/%0d checks passed", nPass, nTotal);
    $finish;
  end

  initial begin
    #1200000;
    if (!finished) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", nPass, nTotal);
      $finish;
    end
  end

endmodule